// File: doc/BRIEF.md
# Layer Command Sequencer

This block sits between a command loader and the compute engines of a neural-network accelerator. The loader pushes 32-bit command words into a first-in first-out queue that holds up to 128 entries. When software sets the enable bit, the sequencer takes the commands out one at a time, in the order they arrived. It decodes each one and either stores layer settings or starts an engine run.

There are two kinds of command. A configure command only updates the layer settings that the engines read: channel count, feature-map size, and the activation and pooling switches. An execute command starts work. A convolution first clears the accumulation scratchpad for one cycle and then pulses the convolution start. A pooling run pulses its own start with no clear. After any start, the sequencer holds until the engine raises done, and only then takes the next command.

An opcode the sequencer does not know sets a sticky error flag and stops dispatch. Software clears the flag through a small 16-bit register port, and that port also reports the queue fill level and the sequencer state.

Top module: `layer_cmd_dispatch`

## Requirements
- R1: After reset, the queue level is 0, the sequencer is idle, the error flag is clear, and all start, clear and configuration outputs are 0.
- R2: The queue accepts a push only while it holds fewer than DEPTH (default 128) words. A push to a full queue is dropped. The level is readable in status bits 11:0.
- R3: While control bit 0 (enable) is 0, no command is removed or acted on, and queued commands stay in place.
- R4: A command with bit 31 = 0 is a configure command, and its opcode sits in bits 30:28. Opcode 0 loads the channel count from bits 15:0. Opcode 1 loads the feature-map size from bits 15:0. Opcode 2 loads the activation switch from bit 0 and the pooling switch from bit 1. With the queue empty and enabled, the new value appears on the fourth rising edge after the push is presented.
- R5: A command with bit 31 = 1 and opcode 0 raises scratch_clr for one cycle, then raises conv_start for one cycle in the next cycle.
- R6: A command with bit 31 = 1 and opcode 1 raises pool_start for one cycle with no scratchpad clear.
- R7: After a start, no further command is taken until eng_done is seen. Commands are carried out in push order.
- R8: Any other opcode sets the sticky error flag (status bit 15 and the err port) and halts dispatch. Writing control bit 1 as 1 clears the flag, and dispatch then resumes.
- R9: Register address 0 is control (bit 0 enable, read back; bit 1 error clear, write only). Address 1 is read-only status: bit 15 error, bits 14:12 state (0 idle), bits 11:0 level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_push | input | 1 | Push a command word into the queue |
| cmd_data | input | 32 | Command word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| eng_done | input | 1 | Engine finished the current run |
| cfg_chan | output | 16 | Channel count for the layer |
| cfg_fmap | output | 16 | Feature-map size for the layer |
| cfg_relu | output | 1 | Activation switch |
| cfg_pool | output | 1 | Pooling switch |
| scratch_clr | output | 1 | One-cycle scratchpad clear |
| conv_start | output | 1 | One-cycle convolution start |
| pool_start | output | 1 | One-cycle pooling start |
| err | output | 1 | Sticky unknown-opcode flag |

## Verification
A configure command pushed into an empty, enabled queue changes the settings on the fourth rising edge after the push is presented. The bench samples the old value after the third edge and the new value after the fourth. For an execute command, the scratchpad clear follows one cycle after decode and the start follows one cycle after that. A scoreboard compares each pulse, at the falling edge where it appears, with the next expected entry in a queue. It flags any pulse that arrives while the modelled engine is still busy. Register reads are combinational, so they are sampled at a falling edge after the settle time each test waits.

// File: rtl/layer_cmd_dispatch.sv
module layer_cmd_dispatch #(
  parameter int DEPTH   = 128,
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_push,
  input  logic [31:0]        cmd_data,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic               eng_done,
  output logic [FIELD_W-1:0] cfg_chan,
  output logic [FIELD_W-1:0] cfg_fmap,
  output logic               cfg_relu,
  output logic               cfg_pool,
  output logic               scratch_clr,
  output logic               conv_start,
  output logic               pool_start,
  output logic               err
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_CLEAR, S_RUN, S_WAIT
  } state_t;

  state_t          state;
  logic [31:0]     mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [LW-1:0]   level;
  logic [31:0]     cmd_q;
  logic            en;

  wire        push_ok = cmd_push && (level != LW'(DEPTH));
  wire        pop     = (state == S_FETCH);
  wire [2:0]  op      = cmd_q[30:28];
  wire        is_exec = cmd_q[31];
  wire        bad_op  = is_exec ? (op > 3'd1) : (op > 3'd2);
  wire        ctrl_wr = reg_wr && !reg_addr;

  assign scratch_clr = (state == S_CLEAR);
  assign conv_start  = (state == S_RUN) && (op == 3'd0);
  assign pool_start  = (state == S_RUN) && (op == 3'd1);
  assign reg_rdata   = reg_addr ? {err, state, 12'(level)} : {15'd0, en};

  always_ff @(posedge clk)
    if (push_ok) mem[wr_ptr] <= cmd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop)     rd_ptr <= rd_ptr + 1'b1;
      level <= level + LW'(push_ok) - LW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en <= 1'b0;
    else if (ctrl_wr) en <= reg_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cmd_q    <= '0;
      err      <= 1'b0;
      cfg_chan <= '0;
      cfg_fmap <= '0;
      cfg_relu <= 1'b0;
      cfg_pool <= 1'b0;
    end else begin
      if (ctrl_wr && reg_wdata[1]) err <= 1'b0;
      case (state)
        S_IDLE:   if (en && !err && level != '0) state <= S_FETCH;
        S_FETCH: begin
          cmd_q <= mem[rd_ptr];
          state <= S_DECODE;
        end
        S_DECODE: begin
          if (bad_op) begin
            err   <= 1'b1;
            state <= S_IDLE;
          end else if (is_exec) begin
            state <= (op == 3'd0) ? S_CLEAR : S_RUN;
          end else begin
            case (op)
              3'd0:    cfg_chan <= cmd_q[FIELD_W-1:0];
              3'd1:    cfg_fmap <= cmd_q[FIELD_W-1:0];
              default: begin
                cfg_relu <= cmd_q[0];
                cfg_pool <= cmd_q[1];
              end
            endcase
            state <= S_IDLE;
          end
        end
        S_CLEAR:  state <= S_RUN;
        S_RUN:    state <= S_WAIT;
        S_WAIT:   if (eng_done) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R2
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !en) |=> (state == S_IDLE)); // R3
  AST_CLEAR_THEN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    scratch_clr |=> conv_start); // R5
  AST_POOL_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pool_start |-> !$past(scratch_clr)); // R6
  AST_WAIT_FOR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !eng_done) |=> (state == S_WAIT)); // R7
  AST_HALT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(scratch_clr || conv_start || pool_start)); // R8
endmodule

// File: tb/layer_cmd_dispatch_tb.sv
module layer_cmd_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_push = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        eng_done = 1'b0;
  logic [15:0] cfg_chan, cfg_fmap;
  logic        cfg_relu, cfg_pool, scratch_clr, conv_start, pool_start, err;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  bit eng_busy = 1'b0;
  int eng_cnt = 0;

  always #10 clk = ~clk;

  layer_cmd_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_data(cmd_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .eng_done(eng_done), .cfg_chan(cfg_chan),
    .cfg_fmap(cfg_fmap), .cfg_relu(cfg_relu), .cfg_pool(cfg_pool),
    .scratch_clr(scratch_clr), .conv_start(conv_start),
    .pool_start(pool_start), .err(err));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(int code);
    int e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R7: actual event %0d expected none", code);
    end else begin
      e = exp_q.pop_front();
      if (e != code) begin
        fails++;
        $display("FAIL R5/R6/R7: actual event %0d expected %0d", code, e);
      end
    end
  endtask

  // Scoreboard monitor and engine model; codes: 1 clear, 2 conv, 3 pool
  initial forever begin
    @(negedge clk);
    eng_done = 1'b0;
    if (eng_busy) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        eng_done = 1'b1;
        eng_busy = 1'b0;
      end
    end
    if (scratch_clr) expect_ev(1);
    if (conv_start || pool_start) begin
      expect_ev(conv_start ? 2 : 3);
      check("R7 start while engine busy", int'(eng_busy), 0);
      eng_busy = 1'b1;
      eng_cnt  = 5;
    end
  end

  task automatic push(logic [31:0] w);
    cmd_push = 1'b1;
    cmd_data = w;
    @(negedge clk);
    cmd_push = 1'b0;
  endtask

  task automatic reg_write(logic a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_check(string req, logic a, int exp);
    reg_addr = a;
    #1;
    check(req, int'(reg_rdata), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 outputs", int'({cfg_chan, cfg_fmap, cfg_relu, cfg_pool,
          scratch_clr, conv_start, pool_start, err}), 0);
    read_check("R1 status", 1'b1, 16'h0000);
    read_check("R9 control", 1'b0, 16'h0000);

    // R3 nothing dispatched while disabled
    push(32'h0000_0005);
    push(32'h1000_001C);
    push(32'h2000_0001);
    idle(10);
    read_check("R3 level held", 1'b1, 16'h0003);
    check("R3 chan unchanged", int'(cfg_chan), 0);

    // R4 configure commands
    reg_write(1'b0, 16'h0001);
    read_check("R9 enable readback", 1'b0, 16'h0001);
    idle(20);
    check("R4 chan", int'(cfg_chan), 5);
    check("R4 fmap", int'(cfg_fmap), 28);
    check("R4 relu", int'(cfg_relu), 1);
    check("R4 pool", int'(cfg_pool), 0);
    read_check("R2 level drained", 1'b1, 16'h0000);

    // R4 timing: new value on the fourth edge after push
    push(32'h0000_0042);
    idle(2);
    check("R4 not yet", int'(cfg_chan), 5);
    idle(1);
    check("R4 on time", int'(cfg_chan), 16'h42);
    idle(3);

    // R5 R6 R7 execute commands in order
    exp_q.push_back(1); exp_q.push_back(2);
    exp_q.push_back(3);
    exp_q.push_back(1); exp_q.push_back(2);
    push(32'h8000_0000);
    push(32'h9000_0000);
    push(32'h8000_0000);
    idle(60);
    check("R7 all events seen", exp_q.size(), 0);
    push(32'h2000_0002);
    idle(10);
    check("R4 flags after exec", int'({cfg_relu, cfg_pool}), 1);

    // R8 unknown configure opcode halts, clear resumes
    push(32'h5000_0000);
    push(32'h0000_0009);
    idle(20);
    check("R8 err port", int'(err), 1);
    check("R8 halted chan", int'(cfg_chan), 16'h42);
    read_check("R8 status", 1'b1, 16'h8001);
    reg_write(1'b0, 16'h0003);
    idle(20);
    check("R8 err cleared", int'(err), 0);
    check("R8 resumed chan", int'(cfg_chan), 9);

    // R8 unknown execute opcode: no events
    push(32'hB000_0000);
    idle(20);
    check("R8 exec err", int'(err), 1);
    reg_write(1'b0, 16'h0003);
    idle(5);
    check("R8 exec err cleared", int'(err), 0);

    // R2 full queue drops extra pushes
    reg_write(1'b0, 16'h0000);
    for (int i = 0; i < DEPTH_TB + 2; i++) push(32'(i));
    read_check("R2 level at full", 1'b1, DEPTH_TB);
    reg_write(1'b0, 16'h0001);
    idle(DEPTH_TB * 4 + 20);
    check("R2 last kept command", int'(cfg_chan), DEPTH_TB - 1);
    read_check("R2 drained", 1'b1, 16'h0000);
    check("R7 no stray events", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam int DEPTH_TB = 128;
endmodule